// File: doc/BRIEF.md
# Dual-Rail Jitter-Attenuating Elastic Store

This block is a small elastic buffer for a dual-rail line signal. A jittery recovered clock writes one positive-rail bit and one negative-rail bit into the buffer as a single entry. A separate smoothed clock, supplied from outside by a loop that this block does not contain, reads the entries back in the same order. The two clocks are asynchronous to each other. Only the read pointer crosses into the write domain, as a Gray-coded value through a two-stage synchroniser. From it, the write side derives a near-full flag.

Run-time inputs choose the following:
- the usable depth, 16 or 32 entries;
- which clock edges capture the input and launch the output;
- a bypass that routes the raw line and the raw clock straight to the outputs.

Reset re-centres the buffer, so that the write side starts half a buffer ahead of the read side. A change of depth while running also re-centres, from the write side alone.

Top module: `jitter_elastic_store`

## Requirements
- R1: Each entry pairs the `lineP` bit and the `lineN` bit sampled on the same write edge. Entries come out on `outP`/`outN` in the order they were written, one per launch edge.
- R2: `depthSel` = 1 gives 32 usable entries and `depthSel` = 0 gives 16. After reset the first depth/2 entries delivered are zero on both rails, and written data follows them.
- R3: `nearFull` is registered on each write sampling edge. It goes high when the write pointer minus the read pointer is at least depth − 2. Pointers are 6-bit modulo-64 counts. The read pointer is the one seen through two write-domain synchroniser stages.
- R4: With `edgeSel` = 1, input is sampled on the falling edge of `wrClk`, and `outP`/`outN` change only on the rising edge of `rdClk`.
- R5: With `edgeSel` = 0, input is sampled on the rising edge of `wrClk`, and `outP`/`outN` change only on the falling edge of `rdClk`.
- R6: While `rstN` is low, `outP`, `outN` and `nearFull` are 0, the storage is cleared, the read pointer is 0 and the write pointer is half the selected depth.
- R7: With `bypass` = 1, `outP` follows `lineP`, `outN` follows `lineN` and `outClk` follows `wrClk`, with no register on the path.
- R8: A change of `depthSel` seen at a write edge re-centres the buffer. The write pointer becomes the synchronised read pointer plus half the new depth, and `nearFull` is low from the second write edge after the change onward.
- R9: With `bypass` = 0, `outClk` follows `rdClk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Recovered (jittery) line clock that writes entries |
| rdClk | input | 1 | Smoothed clock that reads entries |
| rstN | input | 1 | Asynchronous active-low reset; re-centres the buffer |
| lineP | input | 1 | Positive-rail line data |
| lineN | input | 1 | Negative-rail line data |
| depthSel | input | 1 | 1: 32 entries, 0: 16 entries |
| edgeSel | input | 1 | 1: sample on falling write edge, launch on rising read edge; 0: the opposite |
| bypass | input | 1 | 1: route raw line and clock to the outputs |
| outClk | output | 1 | Output clock: `rdClk`, or `wrClk` in bypass |
| outP | output | 1 | Positive-rail output data |
| outN | output | 1 | Negative-rail output data |
| nearFull | output | 1 | High when within two entries of full |

## Verification
The bound assertions check the following on every cycle:
- each pointer index advances by exactly one, modulo the selected depth;
- a depth change clears the near-full flag;
- bypass mirrors data and clock;
- the output clock follows the read clock outside bypass.

Ordering across the two clock domains, the zero-filled first half after reset, and the exact cycle on which the near-full flag rises depend on the relative phase of the two clocks. Only the bench's reference model can show these, under chosen write and read rates. The same holds for the choice of capture and launch edges.

// File: rtl/jes_pkg.sv
package jes_pkg;
  parameter int unsigned JES_DEPTH_MAX = 32;
  localparam int unsigned JES_ADDR_W = $clog2(JES_DEPTH_MAX);
  localparam int unsigned JES_PTR_W = JES_ADDR_W + 1;

  typedef logic [JES_ADDR_W-1:0] jes_idx_t;
  typedef logic [JES_PTR_W-1:0]  jes_ptr_t;

  // one stored line symbol: both rails together
  typedef struct packed {
    logic pos;
    logic neg;
  } jes_pair_t;

  // control -> datapath: where to write, where to read
  typedef struct packed {
    jes_idx_t wrIdx;
    jes_idx_t rdIdx;
  } jes_strobe_t;

  function automatic jes_ptr_t binToGray(input jes_ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic jes_ptr_t grayToBin(input jes_ptr_t g);
    jes_ptr_t b;
    b[JES_PTR_W-1] = g[JES_PTR_W-1];
    for (int i = JES_PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // index mask for the selected depth (full or half of the maximum)
  function automatic jes_idx_t depthMask(input logic big);
    return big ? '1 : jes_idx_t'((JES_DEPTH_MAX / 2) - 1);
  endfunction

  function automatic jes_ptr_t halfDepth(input logic big);
    return big ? jes_ptr_t'(JES_DEPTH_MAX / 2) : jes_ptr_t'(JES_DEPTH_MAX / 4);
  endfunction

  function automatic jes_ptr_t limitLevel(input logic big);
    return big ? jes_ptr_t'(JES_DEPTH_MAX - 2) : jes_ptr_t'((JES_DEPTH_MAX / 2) - 2);
  endfunction
endpackage

// File: rtl/jes_ctrl.sv
module jes_ctrl
  import jes_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        wrClkInt,
  input  logic        rdClkInt,
  input  logic        rstN,
  input  logic        depthSel,
  output jes_strobe_t strb,
  output logic        nearFull
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  jes_ptr_t rdPtr, rdPtrNext, rdGray;
  jes_ptr_t wrPtr, rdSyncBin, occupancy;
  jes_ptr_t rdSync [SYNC_STAGES];
  logic     depthQ;
  logic     limitQ;

  // read domain: free-running pointer, Gray copy registered for crossing
  assign rdPtrNext = rdPtr + 1'b1;

  always_ff @(posedge rdClkInt or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else begin
      rdPtr  <= rdPtrNext;
      rdGray <= binToGray(rdPtrNext);
    end
  end

  // write domain: synchroniser chain for the read pointer
  always_ff @(posedge wrClkInt or negedge rstN) begin
    if (!rstN) begin
      rdSync[0] <= '0;
    end else begin
      rdSync[0] <= rdGray;
    end
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge wrClkInt or negedge rstN) begin
      if (!rstN) begin
        rdSync[s] <= '0;
      end else begin
        rdSync[s] <= rdSync[s-1];
      end
    end
  end

  assign rdSyncBin = grayToBin(rdSync[LAST]);
  assign occupancy = wrPtr - rdSyncBin;

  // write pointer, depth tracking and limit flag
  always_ff @(posedge wrClkInt or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= halfDepth(depthSel);
      depthQ <= depthSel;
      limitQ <= 1'b0;
    end else begin
      depthQ <= depthSel;
      limitQ <= (occupancy >= limitLevel(depthQ));
      if (depthSel != depthQ) begin
        wrPtr <= rdSyncBin + halfDepth(depthSel);
      end else begin
        wrPtr <= wrPtr + 1'b1;
      end
    end
  end

  assign strb.wrIdx = wrPtr[JES_ADDR_W-1:0] & depthMask(depthQ);
  assign strb.rdIdx = rdPtr[JES_ADDR_W-1:0] & depthMask(depthSel);
  assign nearFull   = limitQ;
endmodule

// File: rtl/jes_datapath.sv
module jes_datapath
  import jes_pkg::*;
(
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        wrClkInt,
  input  logic        rdClkInt,
  input  logic        rstN,
  input  logic        bypass,
  input  logic        lineP,
  input  logic        lineN,
  input  jes_strobe_t strb,
  output logic        outClk,
  output logic        outP,
  output logic        outN
);
  jes_pair_t cells [JES_DEPTH_MAX];
  jes_pair_t outQ;

  for (genvar e = 0; e < JES_DEPTH_MAX; e++) begin : g_cell
    jes_pair_t slotQ;
    always_ff @(posedge wrClkInt or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strb.wrIdx == jes_idx_t'(e)) begin
        slotQ <= '{pos: lineP, neg: lineN};
      end
    end
    assign cells[e] = slotQ;
  end

  always_ff @(posedge rdClkInt or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
    end else begin
      outQ <= cells[strb.rdIdx];
    end
  end

  assign outP   = bypass ? lineP : outQ.pos;
  assign outN   = bypass ? lineN : outQ.neg;
  assign outClk = bypass ? wrClk : rdClk;
endmodule

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store
  import jes_pkg::*;
(
  input  logic wrClk,
  input  logic rdClk,
  input  logic rstN,
  input  logic lineP,
  input  logic lineN,
  input  logic depthSel,
  input  logic edgeSel,
  input  logic bypass,
  output logic outClk,
  output logic outP,
  output logic outN,
  output logic nearFull
);
  logic        wrClkInt;
  logic        rdClkInt;
  jes_strobe_t strb;

  // edgeSel=1: capture on falling write edge, launch on rising read edge
  assign wrClkInt = wrClk ^ edgeSel;
  assign rdClkInt = rdClk ^ ~edgeSel;

  jes_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .wrClkInt (wrClkInt),
    .rdClkInt (rdClkInt),
    .rstN     (rstN),
    .depthSel (depthSel),
    .strb     (strb),
    .nearFull (nearFull)
  );

  jes_datapath u_data (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .wrClkInt (wrClkInt),
    .rdClkInt (rdClkInt),
    .rstN     (rstN),
    .bypass   (bypass),
    .lineP    (lineP),
    .lineN    (lineN),
    .strb     (strb),
    .outClk   (outClk),
    .outP     (outP),
    .outN     (outN)
  );
endmodule

// File: rtl/jes_chk.sv
module jes_chk
  import jes_pkg::*;
(
  input logic        wrClk,
  input logic        rdClk,
  input logic        wrClkInt,
  input logic        rdClkInt,
  input logic        rstN,
  input logic        depthSel,
  input logic        bypass,
  input logic        lineP,
  input logic        lineN,
  input logic        outClk,
  input logic        outP,
  input logic        outN,
  input logic        nearFull,
  input jes_strobe_t strb
);
  // R1: read index walks the buffer one entry per launch edge
  p_rd_step_r1: assert property (@(posedge rdClkInt) disable iff (!rstN)
    ($past(rstN) && (depthSel == $past(depthSel)))
      |-> (strb.rdIdx == jes_idx_t'(($past(strb.rdIdx) + 1'b1) & depthMask(depthSel))));

  // R1: write index walks one entry per sampling edge while depth is steady
  p_wr_step_r1: assert property (@(posedge wrClkInt) disable iff (!rstN)
    ($past(rstN) && (depthSel == $past(depthSel)) && ($past(depthSel) == $past(depthSel, 2)))
      |-> (strb.wrIdx == jes_idx_t'(($past(strb.wrIdx) + 1'b1) & depthMask(depthSel))));

  // R8: a depth change re-centres, so the limit flag is clear two edges on
  p_recentre_r8: assert property (@(posedge wrClkInt) disable iff (!rstN)
    ($past(rstN) && (depthSel != $past(depthSel))) |=> ##1 !nearFull);

  // R7: bypass mirrors both rails
  p_bypass_data_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    bypass |-> ((outP == lineP) && (outN == lineN)));

  // R7: bypass mirrors the write clock
  p_bypass_clk_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    bypass |-> (outClk == wrClk));

  // R9: normal mode forwards the read clock
  p_out_clk_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    !bypass |-> (outClk == rdClk));
endmodule

bind jitter_elastic_store jes_chk u_chk (.*);

// File: tb/jitter_elastic_store_tb.sv
`timescale 1ns/1ps
module jitter_elastic_store_tb;
  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic rstN = 1'b0;
  logic lineP = 1'b0;
  logic lineN = 1'b0;
  logic depthSel = 1'b1;
  logic edgeSel = 1'b0;
  logic bypass = 1'b0;
  logic outClk, outP, outN, nearFull;

  int checks = 0;
  int failures = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;
  int wrCnt, rdCnt, s1, s2, pattern, stepNo, depthNow;
  logic [15:0] lfsr = 16'hACE1;
  bit expFlag, sawFlag;
  logic [1:0] curExp;
  logic [1:0] q[$];

  jitter_elastic_store u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .lineP(lineP), .lineN(lineN),
    .depthSel(depthSel), .edgeSel(edgeSel), .bypass(bypass),
    .outClk(outClk), .outP(outP), .outN(outN), .nearFull(nearFull)
  );

  // 50 MHz write clock; read clock slightly slower, offset so edges never meet
  always #10 wrClk = ~wrClk;
  initial begin
    #0.3;
    forever #10.25 rdClk = ~rdClk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write side model: queue of entries plus the synchronised read count
  always @(wrClk) begin
    if (modelOn && (wrClk == ~edgeSel)) begin
      depthNow = depthSel ? 32 : 16;
      q.push_back({lineP, lineN});
      expFlag = (((wrCnt - s2) & 63) >= depthNow - 2);
      wrCnt++;
      s2 = s1;
      s1 = rdCnt & 63;
      #2;
      if (modelOn) begin
        check("R3 nearFull", nearFull, expFlag);
        if (expFlag) sawFlag = 1'b1;
      end
      #3;
      if (modelOn) begin
        stepNo++;
        case (pattern)
          0: {lineP, lineN} = stepNo[1:0];
          1: {lineP, lineN} = stepNo[0] ? 2'b10 : 2'b01;
          default: begin
            lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
            {lineP, lineN} = lfsr[1:0];
          end
        endcase
      end
    end
  end

  // read side model: launch edge pops, opposite edge must not change output
  always @(rdClk) begin
    if (modelOn) begin
      if (rdClk == edgeSel) begin
        rdCnt++;
        if (q.size() > 0) curExp = q.pop_front();
        #2;
        if (modelOn) check(edgeSel ? "R1 R2 R4 data" : "R1 R2 R5 data", {outP, outN}, curExp);
      end else begin
        #2;
        if (modelOn) check(edgeSel ? "R4 hold" : "R5 hold", {outP, outN}, curExp);
      end
    end
  end

  task automatic doReset(input bit big, input bit es, input int pat);
    modelOn = 1'b0;
    rstN = 1'b0;
    bypass = 1'b0;
    depthSel = big;
    edgeSel = es;
    pattern = pat;
    repeat (3) @(posedge wrClk);
    #1;
    check("R6 reset outP", outP, 0);
    check("R6 reset outN", outN, 0);
    check("R6 reset nearFull", nearFull, 0);
    @(posedge wrClk);
    #3;
    q.delete();
    for (int i = 0; i < (big ? 16 : 8); i++) q.push_back(2'b00);
    wrCnt = big ? 16 : 8;
    rdCnt = 0;
    s1 = 0;
    s2 = 0;
    curExp = 2'b00;
    sawFlag = 1'b0;
    stepNo = 0;
    rstN = 1'b1;
    modelOn = 1'b1;
  endtask

  initial begin
    // R2 R3 R5: 32 entries, rising capture / falling launch, counting pattern
    doReset(1'b1, 1'b0, 0);
    repeat (600) @(posedge wrClk);
    check("R3 flag reached at depth 32", sawFlag, 1);

    // R2 R3 R4 R6: reset mid-run re-centres; 16 entries, falling capture, LFSR data
    doReset(1'b0, 1'b1, 2);
    repeat (300) @(posedge wrClk);
    check("R3 flag reached at depth 16", sawFlag, 1);

    // R2 R5: alternating rails, 16 entries
    doReset(1'b0, 1'b0, 1);
    repeat (150) @(posedge wrClk);

    // R8: depth change while half-full of a 32 buffer
    doReset(1'b1, 1'b0, 0);
    repeat (20) @(posedge wrClk);
    modelOn = 1'b0;
    @(posedge wrClk);
    #5;
    depthSel = 1'b0;
    @(posedge wrClk);
    for (int i = 0; i < 60; i++) begin
      @(posedge wrClk);
      #4;
      check("R8 flag low after re-centre", nearFull, 0);
    end

    // R7: bypass passes data and clock straight through
    doReset(1'b1, 1'b0, 0);
    repeat (5) @(posedge wrClk);
    modelOn = 1'b0;
    @(posedge wrClk);
    #6;
    bypass = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(posedge wrClk);
      #3;
      {lineP, lineN} = 2'(i);
      #1;
      check("R7 bypass outP", outP, int'(lineP));
      check("R7 bypass outN", outN, int'(lineN));
      check("R7 bypass clock high", outClk, 1);
      #8;
      check("R7 bypass clock low", outClk, 0);
    end

    // R9: normal mode forwards the read clock
    bypass = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge rdClk);
      #3;
      check("R9 outClk high", outClk, 1);
      @(negedge rdClk);
      #3;
      check("R9 outClk low", outClk, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule